// File: doc/BRIEF.md
# Virtual Converter Frame Packer

This block sits between the sample sources of a dual-channel RF sampling converter and the transport layer of a multi-lane serial link. Its sources are two full-rate converter channels and up to four digital downconverters, each able to deliver a real (I) or complex (I/Q) stream. A static operating mode picks which of these streams become numbered virtual-converter slots, and how many slots exist (M). Each slot is a 16-bit sample, so the physical channel count no longer dictates the converter count that the link sees.

Once every stream the mode needs is valid in the same cycle, the block captures one sample per slot and packs them into one transport frame. The frame is spread over L lanes with F octets per lane, and each lane sends one octet per clock. A per-lane valid and a frame-start flag go with the octets. The link layout must carry exactly the slot octets, and a layout that does not is flagged and never sent. Line coding, scrambling, link synchronisation and the decimation filters are outside this block.

Top module: `vcp_frame_packer`

## Requirements
- R1: With `cfg_mode` = 0 (full bandwidth) there are two slots whatever `cfg_cplx` is. Slot 0 carries `adc_a` and slot 1 carries `adc_b`.
- R2: With `cfg_mode` = 1 (one downconverter), real selection gives one slot holding DDC0 I. Complex selection gives two slots, DDC0 I then DDC0 Q.
- R3: With `cfg_mode` = 2 (two downconverters), real selection gives two slots, DDC0 I then DDC1 I. Complex selection gives four slots: DDC0 I, DDC0 Q, DDC1 I, DDC1 Q.
- R4: With `cfg_mode` = 3 (four downconverters), real selection gives four slots holding the I output of DDC0 to DDC3. Complex selection gives eight slots with each DDC's I directly followed by its Q, DDC0 first. DDC d occupies bits [16d+15:16d] of `ddc_i` and `ddc_q`.
- R5: Frame octet k (0 ≤ k < 2M) is the high byte of slot k/2 when k is even and its low byte when k is odd. Lane l carries octets l·F to l·F+F−1, one per cycle in ascending order, on bits [8l+7:8l] of `lane_data`. Octet cycle 0 is on the outputs in the cycle after the capturing clock edge.
- R6: During a frame, `lane_vld` is high on lanes 0 to L−1 for exactly F cycles and low on every other lane. A lane whose valid is low drives zero data.
- R7: A frame is captured at a clock edge only when every input the mode uses is valid: both `adc_a_vld` and `adc_b_vld` in mode 0, and `ddc_vld` bits 0 to n−1 for n downconverters. The valid bits of unused sources are ignored.
- R8: `lane_sof` is high on every active lane in octet cycle 0 of each frame, and low otherwise.
- R9: A configuration is legal when 1 ≤ L ≤ 8, 1 ≤ F ≤ 16 and L·F = 2M. If it is illegal, `cfg_err` goes high from the next clock edge and no frame is captured.
- R10: Changing the configuration during a frame alters neither the remaining octets nor the active lane set of that frame. The new configuration governs the next frame captured.
- R11: While a frame is in progress, sample inputs are ignored except in its last octet cycle. A capture in that cycle starts the next frame with no gap.
- R12: Reset is synchronous and active high. After reset, `lane_vld`, `lane_sof`, `lane_data` and `cfg_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Operating mode: 0 full bandwidth, 1/2/3 one/two/four downconverters |
| cfg_cplx | input | 1 | 1 selects complex (I/Q) downconverter output |
| cfg_lanes | input | 4 | Lane count L |
| cfg_octets | input | 5 | Octets per lane per frame F |
| adc_a | input | 16 | Full-rate channel A sample |
| adc_a_vld | input | 1 | Channel A sample valid |
| adc_b | input | 16 | Full-rate channel B sample |
| adc_b_vld | input | 1 | Channel B sample valid |
| ddc_i | input | 64 | In-phase samples, 16 bits per downconverter |
| ddc_q | input | 64 | Quadrature samples, 16 bits per downconverter |
| ddc_vld | input | 4 | Per-downconverter sample valid (I and Q together) |
| lane_data | output | 64 | One octet per lane |
| lane_vld | output | 8 | Per-lane octet valid |
| lane_sof | output | 8 | Per-lane first-octet-of-frame flag |
| cfg_err | output | 1 | Illegal link configuration |

## Verification
Four properties are checked on every cycle. Active lanes always form a contiguous group from lane 0. A frame start appears on all active lanes together. No frame starts while the configuration is flagged. Each frame start follows a cycle in which every required source was valid. A fifth check confirms that the lane set never changes in the middle of a frame. What lands in each octet position, and so the slot mapping of every mode, only the bench's scenarios can show. The same holds for back-to-back capture on the last octet cycle and for stimulus that is ignored in the middle of a frame.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int OCTET_W   = 8;
    localparam int NUM_DDC   = 4;
    localparam int MAX_SLOTS = 2 * NUM_DDC;
    localparam int MAX_LANES = 8;
    localparam int MAX_OCT   = SAMPLE_W / OCTET_W * MAX_SLOTS;
    localparam int LANE_W    = $clog2(MAX_LANES + 1);
    localparam int OCT_CNT_W = $clog2(MAX_OCT + 1);
    localparam int IDX_W     = $clog2(MAX_OCT);

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [OCTET_W-1:0]  octet_t;

    typedef enum logic [1:0] {
        MODE_FULL_BW  = 2'd0,
        MODE_ONE_DDC  = 2'd1,
        MODE_TWO_DDC  = 2'd2,
        MODE_FOUR_DDC = 2'd3
    } vc_mode_e;

    typedef struct packed {
        vc_mode_e               mode;
        logic                   cplx;
        logic [LANE_W-1:0]      lanes;
        logic [OCT_CNT_W-1:0]   octets;
    } link_cfg_t;

    function automatic int ddc_count(vc_mode_e m);
        case (m)
            MODE_ONE_DDC:  return 1;
            MODE_TWO_DDC:  return 2;
            MODE_FOUR_DDC: return 4;
            default:       return 0;
        endcase
    endfunction

    function automatic int slot_count(vc_mode_e m, logic cplx);
        if (m == MODE_FULL_BW) return 2;
        return cplx ? 2 * ddc_count(m) : ddc_count(m);
    endfunction

    function automatic logic cfg_valid(link_cfg_t c);
        int l;
        int f;
        l = int'(c.lanes);
        f = int'(c.octets);
        return (l >= 1) && (l <= MAX_LANES) && (f >= 1) && (f <= MAX_OCT) &&
               (l * f == (SAMPLE_W / OCTET_W) * slot_count(c.mode, c.cplx));
    endfunction

endpackage

// File: rtl/vcp_slot_map.sv
module vcp_slot_map
    import vcp_pkg::*;
(
    input  vc_mode_e             mode,
    input  logic                 cplx,
    input  sample_t              adc_a,
    input  sample_t              adc_b,
    input  logic                 adc_a_vld,
    input  logic                 adc_b_vld,
    input  sample_t              ddc_i [NUM_DDC],
    input  sample_t              ddc_q [NUM_DDC],
    input  logic [NUM_DDC-1:0]   ddc_vld,
    output sample_t              slot_data [MAX_SLOTS],
    output logic                 all_valid
);

    logic [NUM_DDC-1:0] need;

    always_comb begin
        need = '0;
        for (int d = 0; d < NUM_DDC; d++) begin
            if (d < ddc_count(mode)) need[d] = 1'b1;
        end
        if (mode == MODE_FULL_BW) all_valid = adc_a_vld && adc_b_vld;
        else                      all_valid = &(ddc_vld | ~need);
    end

    generate
        for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
            localparam int PAIR = s / 2;
            localparam bit IS_Q = (s % 2) == 1;
            sample_t real_pick;
            sample_t cplx_pick;
            sample_t bw_pick;

            if (s < NUM_DDC) begin : g_real
                assign real_pick = ddc_i[s];
            end else begin : g_noreal
                assign real_pick = '0;
            end

            if (IS_Q) begin : g_q
                assign cplx_pick = ddc_q[PAIR];
            end else begin : g_i
                assign cplx_pick = ddc_i[PAIR];
            end

            if (s == 0) begin : g_bw_a
                assign bw_pick = adc_a;
            end else if (s == 1) begin : g_bw_b
                assign bw_pick = adc_b;
            end else begin : g_bw_none
                assign bw_pick = '0;
            end

            assign slot_data[s] = (mode == MODE_FULL_BW)           ? bw_pick   :
                                  (s >= slot_count(mode, cplx))    ? '0        :
                                  cplx                             ? cplx_pick : real_pick;
        end
    endgenerate

endmodule

// File: rtl/vcp_frame_seq.sv
module vcp_frame_seq
    import vcp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_ok,
    input  logic                  all_valid,
    input  logic [LANE_W-1:0]     cfg_lanes,
    input  logic [OCT_CNT_W-1:0]  cfg_octets,
    output logic                  capture,
    output logic                  active,
    output logic [OCT_CNT_W-1:0]  oct_pos,
    output logic [LANE_W-1:0]     lanes_q,
    output logic [OCT_CNT_W-1:0]  octets_q
);

    logic last;

    assign last    = active && (oct_pos == octets_q - OCT_CNT_W'(1));
    assign capture = cfg_ok && all_valid && (!active || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            oct_pos  <= '0;
            lanes_q  <= '0;
            octets_q <= '0;
        end else if (capture) begin
            active   <= 1'b1;
            oct_pos  <= '0;
            lanes_q  <= cfg_lanes;
            octets_q <= cfg_octets;
        end else if (last) begin
            active   <= 1'b0;
            oct_pos  <= '0;
        end else if (active) begin
            oct_pos  <= oct_pos + OCT_CNT_W'(1);
        end
    end

endmodule

// File: rtl/vcp_lane_mux.sv
module vcp_lane_mux
    import vcp_pkg::*;
(
    input  octet_t                frame_oct [MAX_OCT],
    input  logic                  active,
    input  logic [OCT_CNT_W-1:0]  oct_pos,
    input  logic [LANE_W-1:0]     lanes_q,
    input  logic [OCT_CNT_W-1:0]  octets_q,
    output octet_t                lane_oct [MAX_LANES],
    output logic [MAX_LANES-1:0]  lane_on,
    output logic [MAX_LANES-1:0]  lane_first
);

    localparam int POS_W = $clog2(MAX_LANES * MAX_OCT + MAX_OCT);

    generate
        for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
            logic [POS_W-1:0] pos;
            assign pos = POS_W'(l) * POS_W'(octets_q) + POS_W'(oct_pos);
            assign lane_on[l]    = active && (LANE_W'(l) < lanes_q);
            assign lane_first[l] = lane_on[l] && (oct_pos == '0);
            assign lane_oct[l]   = (lane_on[l] && (pos < POS_W'(MAX_OCT)))
                                   ? frame_oct[pos[IDX_W-1:0]] : '0;
        end
    endgenerate

endmodule

// File: rtl/vcp_frame_packer.sv
module vcp_frame_packer
    import vcp_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [1:0]                        cfg_mode,
    input  logic                              cfg_cplx,
    input  logic [LANE_W-1:0]                 cfg_lanes,
    input  logic [OCT_CNT_W-1:0]              cfg_octets,
    input  logic [SAMPLE_W-1:0]               adc_a,
    input  logic                              adc_a_vld,
    input  logic [SAMPLE_W-1:0]               adc_b,
    input  logic                              adc_b_vld,
    input  logic [NUM_DDC*SAMPLE_W-1:0]       ddc_i,
    input  logic [NUM_DDC*SAMPLE_W-1:0]       ddc_q,
    input  logic [NUM_DDC-1:0]                ddc_vld,
    output logic [MAX_LANES*OCTET_W-1:0]      lane_data,
    output logic [MAX_LANES-1:0]              lane_vld,
    output logic [MAX_LANES-1:0]              lane_sof,
    output logic                              cfg_err
);

    link_cfg_t cfg;
    logic      cfg_ok;

    assign cfg    = '{mode: vc_mode_e'(cfg_mode), cplx: cfg_cplx,
                      lanes: cfg_lanes, octets: cfg_octets};
    assign cfg_ok = cfg_valid(cfg);

    sample_t ddc_i_arr [NUM_DDC];
    sample_t ddc_q_arr [NUM_DDC];

    generate
        for (genvar d = 0; d < NUM_DDC; d++) begin : g_ddc
            assign ddc_i_arr[d] = ddc_i[d*SAMPLE_W +: SAMPLE_W];
            assign ddc_q_arr[d] = ddc_q[d*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    sample_t slot_data [MAX_SLOTS];
    logic    all_valid;

    vcp_slot_map u_map (
        .mode      (cfg.mode),
        .cplx      (cfg.cplx),
        .adc_a     (adc_a),
        .adc_b     (adc_b),
        .adc_a_vld (adc_a_vld),
        .adc_b_vld (adc_b_vld),
        .ddc_i     (ddc_i_arr),
        .ddc_q     (ddc_q_arr),
        .ddc_vld   (ddc_vld),
        .slot_data (slot_data),
        .all_valid (all_valid)
    );

    logic                 capture;
    logic                 active;
    logic [OCT_CNT_W-1:0] oct_pos;
    logic [LANE_W-1:0]    lanes_q;
    logic [OCT_CNT_W-1:0] octets_q;

    vcp_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_ok     (cfg_ok),
        .all_valid  (all_valid),
        .cfg_lanes  (cfg.lanes),
        .cfg_octets (cfg.octets),
        .capture    (capture),
        .active     (active),
        .oct_pos    (oct_pos),
        .lanes_q    (lanes_q),
        .octets_q   (octets_q)
    );

    sample_t frame_q [MAX_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < MAX_SLOTS; s++) frame_q[s] <= '0;
        end else if (capture) begin
            frame_q <= slot_data;
        end
    end

    octet_t frame_oct [MAX_OCT];

    generate
        for (genvar k = 0; k < MAX_OCT; k++) begin : g_oct
            if ((k % 2) == 0) begin : g_hi
                assign frame_oct[k] = frame_q[k/2][SAMPLE_W-1 -: OCTET_W];
            end else begin : g_lo
                assign frame_oct[k] = frame_q[k/2][OCTET_W-1:0];
            end
        end
    endgenerate

    octet_t lane_oct [MAX_LANES];

    vcp_lane_mux u_mux (
        .frame_oct  (frame_oct),
        .active     (active),
        .oct_pos    (oct_pos),
        .lanes_q    (lanes_q),
        .octets_q   (octets_q),
        .lane_oct   (lane_oct),
        .lane_on    (lane_vld),
        .lane_first (lane_sof)
    );

    generate
        for (genvar l = 0; l < MAX_LANES; l++) begin : g_out
            assign lane_data[l*OCTET_W +: OCTET_W] = lane_oct[l];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= !cfg_ok;
    end

endmodule

// File: rtl/vcp_frame_packer_chk.sv
module vcp_frame_packer_chk
    import vcp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            cfg_mode,
    input  logic                  adc_a_vld,
    input  logic                  adc_b_vld,
    input  logic [NUM_DDC-1:0]    ddc_vld,
    input  logic [MAX_LANES-1:0]  lane_vld,
    input  logic [MAX_LANES-1:0]  lane_sof,
    input  logic                  cfg_err
);

    logic sources_ready;

    always_comb begin
        case (cfg_mode)
            2'd0:    sources_ready = adc_a_vld && adc_b_vld;
            2'd1:    sources_ready = ddc_vld[0];
            2'd2:    sources_ready = &ddc_vld[1:0];
            default: sources_ready = &ddc_vld;
        endcase
    end

    AST_START_ON_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (|lane_sof) |-> (lane_sof == lane_vld)); // R8

    AST_LANES_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $onehot0({1'b0, lane_vld} + 9'd1)); // R6

    AST_NO_START_WHEN_BAD_CFG: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !lane_sof[0]); // R9

    AST_START_NEEDS_SOURCES: assert property (@(posedge clk) disable iff (rst)
        lane_sof[0] |-> $past(sources_ready)); // R7

    AST_LANE_SET_HELD: assert property (@(posedge clk) disable iff (rst)
        ((|lane_vld) && !lane_sof[0]) |-> (lane_vld == $past(lane_vld))); // R10

endmodule

bind vcp_frame_packer vcp_frame_packer_chk u_chk (.*);

// File: tb/sim_vcp_frame_packer.sv
`timescale 1ns/1ps
module sim_vcp_frame_packer;
    import vcp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_cplx = 1'b0;
    logic [3:0]  cfg_lanes = 4'd1;
    logic [4:0]  cfg_octets = 5'd4;
    logic [15:0] adc_a = '0, adc_b = '0;
    logic        adc_a_vld = 1'b0, adc_b_vld = 1'b0;
    logic [63:0] ddc_i = '0, ddc_q = '0;
    logic [3:0]  ddc_vld = '0;
    logic [63:0] lane_data;
    logic [7:0]  lane_vld, lane_sof;
    logic        cfg_err;

    always #2 clk = ~clk;

    vcp_frame_packer u0 (.*);

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct packed {
        logic [1:0] mode;
        logic       cplx;
        logic [3:0] L;
        logic [4:0] F;
        logic [7:0] seed;
        logic [3:0] dv;
        logic [1:0] av;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 4'd1, 5'd4, 8'h00, 4'h0, 2'b11},
        '{2'd0, 1'b1, 4'd2, 5'd2, 8'h11, 4'h0, 2'b11},
        '{2'd1, 1'b0, 4'd1, 5'd2, 8'h22, 4'h1, 2'b00},
        '{2'd1, 1'b1, 4'd2, 5'd2, 8'h33, 4'h1, 2'b00},
        '{2'd2, 1'b0, 4'd2, 5'd2, 8'h44, 4'h3, 2'b00},
        '{2'd2, 1'b1, 4'd4, 5'd2, 8'h55, 4'h3, 2'b00},
        '{2'd2, 1'b1, 4'd2, 5'd4, 8'h66, 4'h3, 2'b00},
        '{2'd3, 1'b0, 4'd4, 5'd2, 8'h77, 4'hF, 2'b00},
        '{2'd3, 1'b1, 4'd8, 5'd2, 8'h88, 4'hF, 2'b00},
        '{2'd3, 1'b1, 4'd4, 5'd4, 8'h99, 4'hF, 2'b00},
        '{2'd3, 1'b1, 4'd2, 5'd8, 8'hAA, 4'hF, 2'b11}
    };

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] smp_i(logic [7:0] seed, int d);
        return {seed ^ (8'h10 + 8'(d)), 8'h20 + 8'(d)};
    endfunction
    function automatic logic [15:0] smp_q(logic [7:0] seed, int d);
        return {seed ^ (8'h30 + 8'(d)), 8'h40 + 8'(d)};
    endfunction

    function automatic logic [15:0] slot_val(logic [1:0] mode, logic cplx, logic [7:0] seed, int s);
        if (mode == 2'd0) begin
            if (s == 0) return {seed ^ 8'h51, 8'h52};
            if (s == 1) return {seed ^ 8'h61, 8'h62};
            return '0;
        end
        if (cplx) return (s % 2 == 1) ? smp_q(seed, s / 2) : smp_i(seed, s / 2);
        return smp_i(seed, s);
    endfunction

    function automatic logic [63:0] exp_data(vec_t v, int c);
        logic [63:0] r = '0;
        for (int l = 0; l < 8; l++) begin
            if (l < int'(v.L)) begin
                int k = l * int'(v.F) + c;
                logic [15:0] s = slot_val(v.mode, v.cplx, v.seed, k / 2);
                r[l*8 +: 8] = (k % 2 == 0) ? s[15:8] : s[7:0];
            end
        end
        return r;
    endfunction

    task automatic drive(vec_t v);
        cfg_mode   = v.mode;
        cfg_cplx   = v.cplx;
        cfg_lanes  = v.L;
        cfg_octets = v.F;
        adc_a = {v.seed ^ 8'h51, 8'h52};
        adc_b = {v.seed ^ 8'h61, 8'h62};
        for (int d = 0; d < 4; d++) begin
            ddc_i[d*16 +: 16] = smp_i(v.seed, d);
            ddc_q[d*16 +: 16] = smp_q(v.seed, d);
        end
        ddc_vld   = v.dv;
        adc_a_vld = v.av[1];
        adc_b_vld = v.av[0];
    endtask

    task automatic drop_valids();
        ddc_vld = '0; adc_a_vld = 1'b0; adc_b_vld = 1'b0;
    endtask

    // Called at a falling edge; checks one whole frame (R5, R6, R8).
    task automatic run_frame(vec_t v, string tag, int disturb_at);
        vec_t alt;
        logic [63:0] vmask;
        drive(v);
        @(posedge clk); #1;
        drop_valids();
        vmask = 64'((64'd1 << v.L) - 1);
        for (int c = 0; c < int'(v.F); c++) begin
            check({tag, " R5 data"}, lane_data, exp_data(v, c));
            check("R6 lane valid", {56'd0, lane_vld}, vmask);
            check("R8 frame start", {56'd0, lane_sof}, (c == 0) ? vmask : 64'd0);
            if (c == disturb_at) begin
                alt = '{2'd1, 1'b0, 4'd1, 5'd2, v.seed ^ 8'hFF, 4'hF, 2'b11};
                drive(alt);
            end else if (c == disturb_at + 1) begin
                drop_valids();
            end
            @(posedge clk); #1;
        end
        check("R11 idle after frame", {56'd0, lane_vld}, 64'd0);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        string mtag [4] = '{"R1", "R2", "R3", "R4"};
        vec_t  v;

        // R12: reset with live stimulus
        drive(VECS[7]);
        repeat (3) @(posedge clk);
        #1;
        check("R12 lane_vld in reset", {56'd0, lane_vld}, 64'd0);
        check("R12 lane_sof in reset", {56'd0, lane_sof}, 64'd0);
        check("R12 lane_data in reset", lane_data, 64'd0);
        check("R12 cfg_err in reset", {63'd0, cfg_err}, 64'd0);
        drop_valids();
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: every mode and layout
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VECS[i], mtag[VECS[i].mode], -1);
        end

        // R7: one required downconverter missing
        v = '{2'd3, 1'b1, 4'd4, 5'd4, 8'h12, 4'b0111, 2'b11};
        drive(v);
        @(posedge clk); #1;
        check("R7 missing ddc3 valid", {56'd0, lane_vld}, 64'd0);
        @(negedge clk);
        v = '{2'd0, 1'b0, 4'd2, 5'd2, 8'h13, 4'hF, 2'b01};
        drive(v);
        @(posedge clk); #1;
        check("R7 missing channel A valid", {56'd0, lane_vld}, 64'd0);
        drop_valids();
        @(negedge clk);

        // R9: illegal layouts
        v = '{2'd2, 1'b1, 4'd4, 5'd4, 8'h14, 4'hF, 2'b11};
        drive(v);
        @(posedge clk); #1;
        check("R9 cfg_err for L*F != 2M", {63'd0, cfg_err}, 64'd1);
        check("R9 no frame for bad cfg", {56'd0, lane_vld}, 64'd0);
        @(negedge clk);
        cfg_lanes = 4'd0; cfg_octets = 5'd8; cfg_mode = 2'd2;
        @(posedge clk); #1;
        check("R9 cfg_err for zero lanes", {63'd0, cfg_err}, 64'd1);
        check("R9 no frame for zero lanes", {56'd0, lane_vld}, 64'd0);
        drop_valids();
        @(negedge clk);
        cfg_lanes = 4'd4; cfg_octets = 5'd2;
        @(posedge clk); #1;
        check("R9 cfg_err clears", {63'd0, cfg_err}, 64'd0);
        @(negedge clk);

        // R10 / R11: config and samples change mid-frame
        run_frame('{2'd3, 1'b1, 4'd2, 5'd8, 8'h3C, 4'hF, 2'b00}, "R10 R11 R4", 2);
        run_frame('{2'd1, 1'b0, 4'd1, 5'd2, 8'h3D, 4'h1, 2'b00}, "R10 R2", -1);

        // R11: back-to-back capture on the last octet cycle
        v = '{2'd2, 1'b1, 4'd4, 5'd2, 8'h0A, 4'h3, 2'b00};
        drive(v);
        @(posedge clk); #1;
        v.seed = 8'h0B;
        drive(v);
        v.seed = 8'h0A;
        check("R11 b2b first frame c0", lane_data, exp_data(v, 0));
        check("R11 b2b first sof", {56'd0, lane_sof}, 64'h0F);
        @(posedge clk); #1;
        check("R11 mid-frame input ignored", lane_data, exp_data(v, 1));
        @(posedge clk); #1;
        v.seed = 8'h0B;
        drop_valids();
        check("R11 b2b second frame c0", lane_data, exp_data(v, 0));
        check("R11 b2b second sof", {56'd0, lane_sof}, 64'h0F);
        @(posedge clk); #1;
        check("R11 b2b second frame c1", lane_data, exp_data(v, 1));
        @(posedge clk); #1;
        check("R11 idle after b2b", {56'd0, lane_vld}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule